// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block is the programmable feedback divider of a frequency synthesizer loop, written as synchronous logic on the fast input clock. A small prescaler counts input cycles and switches between a modulus of P and P+1. Two back-end counters sit behind it. The first decides how many prescaler periods use the longer modulus (the "swallow" count A). The second counts prescaler periods up to B. When it reaches that terminal count, it restarts the whole chain, prescaler included, and accepts new settings.

The result is an output period of N = B·P + A input cycles, provided A is not larger than B. The divided output is high for the last prescaler period of each output period. A final flip-flop retimes that output on the input clock. The retiming sample can be taken on every input cycle, or only on every second or every fourth cycle.

Settings are applied at period boundaries only, so they can be changed at any time without producing a short or long output pulse. Settings that cannot be realised are reported and are never loaded.

Top module: `swallow_divider`

## Requirements
- R1: A synchronous reset clears every counter. In the first cycle after the reset edge, the divided output, the retimed output and the error flag are all low, and a new output period begins.
- R2: The prescaler select encodes the base modulus P as follows: 0 gives P=2, 1 gives P=4 and 2 gives P=8. The output period is B·P + A input cycles.
- R3: The first A prescaler periods of each output period use modulus P+1 and the remaining ones use P. As a result, the last prescaler period is P+1 cycles long when A equals B, and P cycles long otherwise.
- R4: The divided output is high for exactly one prescaler period per output period, which is the last one. Counting cycles from the start of a period, it rises at cycle N minus the length of that last period, and it falls when the next period starts.
- R5: New A, B and P values take effect only at terminal count. A change made during a period, including one presented in the period's final cycle, leaves that period's length unchanged and governs the next period.
- R6: A setting is invalid when A > B, when B = 0, or when the select is 3. The error flag shows validity one cycle after the inputs. An invalid setting is never loaded, and the divider keeps the settings it already has.
- R7: The retimed output copies the divided output at sampling edges and holds its value between them. A retime select of 0 samples on every input cycle, 1 samples on every second cycle and 2 or 3 samples on every fourth cycle. The sampling phase counter starts at zero on reset, and the edge that ends the first cycle after reset is a sampling edge.
- R8: If the inputs are invalid while reset is applied, the divider loads its default settings (P=2, A=0, B=2, so N=4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate input clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 2 | Prescaler modulus select (0: 2/3, 1: 4/5, 2: 8/9, 3: invalid) |
| a_word | input | AW | Swallow count A |
| b_word | input | BW | Period count B |
| rt_sel | input | 2 | Retime rate (0: every cycle, 1: every 2nd cycle, 2/3: every 4th cycle) |
| div_out | output | 1 | Divided output, registered |
| div_retimed | output | 1 | Divided output after the retiming flip-flop |
| cfg_err | output | 1 | Invalid setting flag, registered |

## Verification
The delicate coincidence is a settings change that arrives in the same cycle as terminal count. The bench presents new words in exactly the last cycle of a period, and then again one cycle later. From the rising-edge times of the following periods, the bench judges whether the load landed in the period just starting or waited a full period. The same timing is repeated with invalid words, to show that a rejected setting leaves the period length unchanged while the flag rises.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  typedef enum logic [1:0] {
    PS_2   = 2'd0,
    PS_4   = 2'd1,
    PS_8   = 2'd2,
    PS_BAD = 2'd3
  } psel_e;

  localparam int P_MAX = 8;
  localparam int PCW   = $clog2(P_MAX + 2);

  function automatic logic [PCW-1:0] p_value(input logic [1:0] sel);
    case (sel)
      PS_2:    p_value = PCW'(2);
      PS_4:    p_value = PCW'(4);
      default: p_value = PCW'(8);
    endcase
  endfunction

endpackage

// File: rtl/swdiv_cfg.sv
module swdiv_cfg
  import swdiv_pkg::*;
#(
  parameter int AW       = 6,
  parameter int BW       = 6,
  parameter int DEF_PSEL = 0,
  parameter int DEF_A    = 0,
  parameter int DEF_B    = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [1:0]     psel_in,
  input  logic [AW-1:0]  a_in,
  input  logic [BW-1:0]  b_in,
  output logic [AW-1:0]  a_q,
  output logic [BW-1:0]  b_q,
  output logic [PCW-1:0] p_q,
  output logic [BW-1:0]  b_nxt,
  output logic           cfg_err
);
  localparam int CW = (AW > BW) ? AW : BW;

  logic valid;

  always_comb begin
    valid = (psel_in != PS_BAD) && (b_in != '0) && (CW'(a_in) <= CW'(b_in));
    b_nxt = (load && valid) ? b_in : b_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err <= 1'b0;
      if (valid) begin
        a_q <= a_in;
        b_q <= b_in;
        p_q <= p_value(psel_in);
      end else begin
        a_q <= AW'(DEF_A);
        b_q <= BW'(DEF_B);
        p_q <= p_value(2'(DEF_PSEL));
      end
    end else begin
      cfg_err <= !valid;
      if (load && valid) begin
        a_q <= a_in;
        b_q <= b_in;
        p_q <= p_value(psel_in);
      end
    end
  end

endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
  import swdiv_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [PCW-1:0] p_val,
  input  logic           swallow,
  output logic           wrap,
  output logic [PCW-1:0] cnt
);
  logic [PCW-1:0] modulus;

  always_comb begin
    modulus = p_val + PCW'(swallow);
    wrap    = (cnt == modulus - PCW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || wrap) cnt <= '0;
    else             cnt <= cnt + PCW'(1);
  end

endmodule

// File: rtl/swdiv_backend.sv
module swdiv_backend #(
  parameter int AW = 6,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap,
  input  logic [AW-1:0] a_q,
  input  logic [BW-1:0] b_q,
  input  logic [BW-1:0] b_nxt,
  output logic          swallow,
  output logic          term,
  output logic          div_q
);
  localparam int CW = (AW > BW) ? AW : BW;

  logic [BW-1:0] per_cnt;
  logic [BW-1:0] per_nxt;

  always_comb begin
    swallow = CW'(per_cnt) < CW'(a_q);
    term    = wrap && (per_cnt == b_q - BW'(1));
    if (term)      per_nxt = '0;
    else if (wrap) per_nxt = per_cnt + BW'(1);
    else           per_nxt = per_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt <= '0;
      div_q   <= 1'b0;
    end else begin
      per_cnt <= per_nxt;
      div_q   <= (per_nxt == b_nxt - BW'(1));
    end
  end

endmodule

// File: rtl/swdiv_retime.sv
module swdiv_retime #(
  parameter int PHW = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       d,
  input  logic [1:0] rt_sel,
  output logic       q
);
  logic [PHW-1:0] ph;
  logic           en;

  always_comb begin
    case (rt_sel)
      2'd0:    en = 1'b1;
      2'd1:    en = (ph[0] == 1'b0);
      default: en = (ph[1:0] == 2'b00);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0;
      q  <= 1'b0;
    end else begin
      ph <= ph + PHW'(1);
      if (en) q <= d;
    end
  end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int AW       = 6,
  parameter int BW       = 6,
  parameter int DEF_PSEL = 0,
  parameter int DEF_A    = 0,
  parameter int DEF_B    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    psel,
  input  logic [AW-1:0] a_word,
  input  logic [BW-1:0] b_word,
  input  logic [1:0]    rt_sel,
  output logic          div_out,
  output logic          div_retimed,
  output logic          cfg_err
);
  logic [AW-1:0]  cfg_a;
  logic [BW-1:0]  cfg_b;
  logic [BW-1:0]  cfg_b_nxt;
  logic [PCW-1:0] cfg_p;
  logic [PCW-1:0] pre_cnt;
  logic           pre_wrap;
  logic           swallow;
  logic           term;

  swdiv_cfg #(
    .AW(AW), .BW(BW), .DEF_PSEL(DEF_PSEL), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(term),
    .psel_in(psel), .a_in(a_word), .b_in(b_word),
    .a_q(cfg_a), .b_q(cfg_b), .p_q(cfg_p), .b_nxt(cfg_b_nxt),
    .cfg_err(cfg_err)
  );

  swdiv_prescaler u_pre (
    .clk(clk), .rst(rst), .p_val(cfg_p), .swallow(swallow),
    .wrap(pre_wrap), .cnt(pre_cnt)
  );

  swdiv_backend #(.AW(AW), .BW(BW)) u_back (
    .clk(clk), .rst(rst), .wrap(pre_wrap),
    .a_q(cfg_a), .b_q(cfg_b), .b_nxt(cfg_b_nxt),
    .swallow(swallow), .term(term), .div_q(div_out)
  );

  swdiv_retime #(.PHW(2)) u_rt (
    .clk(clk), .rst(rst), .d(div_out), .rt_sel(rt_sel), .q(div_retimed)
  );

endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk
  import swdiv_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     psel,
  input logic [AW-1:0]  a_word,
  input logic [BW-1:0]  b_word,
  input logic [1:0]     rt_sel,
  input logic           div_out,
  input logic           div_retimed,
  input logic           cfg_err,
  input logic           term,
  input logic           pre_wrap,
  input logic [PCW-1:0] pre_cnt,
  input logic [AW-1:0]  cfg_a,
  input logic [BW-1:0]  cfg_b,
  input logic [PCW-1:0] cfg_p
);
  localparam int CW = (AW > BW) ? AW : BW;

  // R1: outputs low right after a reset edge
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!div_out && !div_retimed && !cfg_err));

  // R5: the active settings move only at terminal count
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !term |=> ($stable(cfg_a) && $stable(cfg_b) && $stable(cfg_p)));

  // R6: an invalid setting raises the flag one cycle later
  p_flag_r6: assert property (@(posedge clk) disable iff (rst)
    ((CW'(a_word) > CW'(b_word)) || (b_word == '0) || (psel == PS_BAD)) |=> cfg_err);

  // R7: full-rate retiming is a one-cycle copy of the divided output
  p_retime_full_r7: assert property (@(posedge clk) disable iff (rst)
    (rt_sel == 2'd0) |=> (div_retimed == $past(div_out)));

  // R4: the divided output rises only at a prescaler boundary
  p_rise_at_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(div_out) && !$past(rst)) |-> $past(pre_wrap));

  // R3: the prescaler restarts after every wrap
  p_pre_restart_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(pre_wrap) && !$past(rst)) |-> (pre_cnt == '0));

endmodule

bind swallow_divider swdiv_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .a_word(a_word), .b_word(b_word),
  .rt_sel(rt_sel), .div_out(div_out), .div_retimed(div_retimed),
  .cfg_err(cfg_err), .term(term), .pre_wrap(pre_wrap), .pre_cnt(pre_cnt),
  .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_p(cfg_p)
);

// File: tb/sim_swallow_divider.sv
`timescale 1ns/1ps
module sim_swallow_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] psel = 2'd0;
  logic [5:0] a_w = 6'd0;
  logic [5:0] b_w = 6'd2;
  logic [1:0] rtsel = 2'd0;
  logic       div_out, div_retimed, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  swallow_divider u0 (
    .clk(clk), .rst(rst), .psel(psel), .a_word(a_w), .b_word(b_w),
    .rt_sel(rtsel), .div_out(div_out), .div_retimed(div_retimed),
    .cfg_err(cfg_err)
  );

  // {psel, A, B, rt_sel, N, high width}
  localparam logic [27:0] VEC [6] = '{
    {2'd0, 6'd1, 6'd3, 2'd0, 8'd7,  4'd2},
    {2'd1, 6'd2, 6'd5, 2'd1, 8'd22, 4'd4},
    {2'd2, 6'd3, 6'd3, 2'd2, 8'd27, 4'd9},
    {2'd0, 6'd0, 6'd2, 2'd3, 8'd4,  4'd2},
    {2'd2, 6'd5, 6'd7, 2'd1, 8'd61, 4'd8},
    {2'd1, 6'd4, 6'd4, 2'd0, 8'd20, 4'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // retiming monitor: own phase count, compares at every cycle
  logic rst_seen = 1'b0;
  always @(posedge clk) rst_seen <= rst;
  int  rt_bad = 0;
  int  bph = 0;
  bit  mon_ok = 1'b0;
  bit  prev_en = 1'b0, prev_div = 1'b0, prev_rt = 1'b0;
  always @(negedge clk) begin
    int rr;
    bit expv;
    rr = (rtsel == 2'd0) ? 1 : (rtsel == 2'd1) ? 2 : 4;
    if (rst_seen) begin
      bph = 0;
      mon_ok = 1'b1;
    end else if (mon_ok) begin
      expv = prev_en ? prev_div : prev_rt;
      if (div_retimed !== expv) rt_bad++;
      bph++;
    end
    prev_en  = ((bph % rr) == 0);
    prev_div = div_out;
    prev_rt  = div_retimed;
  end

  int r0, r1, r2, f0, err_after;

  task automatic run(input logic [1:0] ps0, input logic [5:0] a0, input logic [5:0] b0,
                     input logic [1:0] rt, input int chg,
                     input logic [1:0] ps1, input logic [5:0] a1, input logic [5:0] b1,
                     input int lim);
    int nr;
    bit prev;
    @(negedge clk);
    psel = ps0; a_w = a0; b_w = b0; rtsel = rt; rst = 1'b1;
    @(negedge clk);
    rt_bad = 0;
    // R1: state right after the reset edge
    chk(div_out == 1'b0 && div_retimed == 1'b0 && cfg_err == 1'b0, "R1 reset outputs",
        {div_out, div_retimed, cfg_err}, 0);
    rst = 1'b0;
    prev = 1'b0; nr = 0;
    r0 = -1; r1 = -1; r2 = -1; f0 = -1; err_after = -1;
    for (int t = 0; t < lim; t++) begin
      if (div_out && !prev) begin
        if (nr == 0) r0 = t;
        else if (nr == 1) r1 = t;
        else if (nr == 2) r2 = t;
        nr++;
      end
      if (!div_out && prev && f0 < 0) f0 = t;
      prev = div_out;
      if (t == chg + 1) err_after = int'(cfg_err);
      if (t == chg) begin
        psel = ps1; a_w = a1; b_w = b1;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    foreach (VEC[i]) begin
      logic [1:0] vp, vr;
      logic [5:0] va, vb;
      int vn, vw;
      {vp, va, vb, vr} = VEC[i][27:12];
      vn = int'(VEC[i][11:4]);
      vw = int'(VEC[i][3:0]);
      run(vp, va, vb, vr, -5, vp, va, vb, 2 * vn + 2);
      // R2 / R3 / R4: first rise, first fall, second rise
      chk(r0 == vn - vw, "R3 first rise", r0, vn - vw);
      chk(f0 == vn, "R4 fall at period end", f0, vn);
      chk(r1 == 2 * vn - vw, "R2 period length", r1, 2 * vn - vw);
      chk(rt_bad == 0, "R7 retimed output", rt_bad, 0);
      chk(cfg_err == 1'b0, "R6 flag low on valid", int'(cfg_err), 0);
    end

    // R5: change presented in the final cycle of the first period (t=6)
    run(2'd0, 6'd1, 6'd3, 2'd0, 6, 2'd1, 6'd1, 6'd2, 24);
    chk(r1 == 12, "R5 same-cycle load, rise 2", r1, 12);
    chk(r2 == 21, "R5 same-cycle load, rise 3", r2, 21);
    chk(err_after == 0, "R6 flag low after valid change", err_after, 0);

    // R5: change one cycle after terminal count waits a whole period
    run(2'd0, 6'd1, 6'd3, 2'd0, 7, 2'd1, 6'd1, 6'd2, 24);
    chk(r1 == 12, "R5 late load, rise 2", r1, 12);
    chk(r2 == 19, "R5 late load, rise 3", r2, 19);

    // R5: change mid-period
    run(2'd0, 6'd1, 6'd3, 2'd1, 2, 2'd1, 6'd1, 6'd2, 24);
    chk(r0 == 5, "R5 mid-period change, rise 1", r0, 5);
    chk(r2 == 21, "R5 mid-period change, rise 3", r2, 21);
    chk(rt_bad == 0, "R7 half-rate retime across change", rt_bad, 0);

    // R6: A > B ignored
    run(2'd0, 6'd1, 6'd3, 2'd0, 2, 2'd0, 6'd4, 6'd3, 24);
    chk(err_after == 1, "R6 flag on A>B", err_after, 1);
    chk(r2 == 19, "R6 A>B not loaded", r2, 19);

    // R6: select 3 ignored, presented at terminal count
    run(2'd0, 6'd1, 6'd3, 2'd2, 6, 2'd3, 6'd1, 6'd3, 24);
    chk(err_after == 1, "R6 flag on select 3", err_after, 1);
    chk(r2 == 19, "R6 select 3 not loaded", r2, 19);
    chk(rt_bad == 0, "R7 quarter-rate retime", rt_bad, 0);

    // R6: B = 0 ignored
    run(2'd0, 6'd1, 6'd3, 2'd0, 2, 2'd0, 6'd0, 6'd0, 24);
    chk(err_after == 1, "R6 flag on B=0", err_after, 1);
    chk(r2 == 19, "R6 B=0 not loaded", r2, 19);

    // R8: invalid inputs during reset load defaults (N=4, width 2)
    run(2'd0, 6'd5, 6'd2, 2'd0, 0, 2'd0, 6'd5, 6'd2, 12);
    chk(r0 == 2, "R8 default first rise", r0, 2);
    chk(r1 == 6, "R8 default period", r1, 6);
    chk(err_after == 1, "R8 flag with defaults", err_after, 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule